// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the register front end of a two-channel serial controller. A byte-wide synchronous bus slave reaches two ports on each channel. The command port works indirectly: the first write loads a register pointer and the next access uses the register that pointer selects. The data port sends a byte out of the transmit strobe interface or takes one byte from the channel's receive FIFO. Each FIFO is filled from a simple valid/data push input.

Interrupt state is kept in one pending register, held on channel A, for both channels. The global interrupt enable and the receive interrupt mode also come from channel A. The transmit interrupt enable belongs to each channel. A local loopback option feeds each transmitted byte back into that channel's own receive FIFO. There is no bit serializer and no baud generator: the block only holds the registers, the status and the interrupt request.

Top module: `dsc_regif`

## Requirements
- R1: Address bit 3 selects the channel (0 = A, 1 = B). Bits 2:0 select the port: offset 1 is the command port and offset 5 is the data port. A write to any other offset has no effect, and a read of any other offset returns 0x00.
- R2: A command-port write made while no pointer is pending loads the pointer with bits 3:0 of the byte and marks it pending. The next command-port write stores its byte in the write register the pointer selects, then returns the pointer to 0 and clears the pending state.
- R3: A command-port read returns the read register that the pointer selects, then returns the pointer to 0 and clears the pending state. All read data is registered and is valid in the cycle after the read strobe. A read strobe in a cycle with a write strobe is ignored.
- R4: Read register 0 has bit 2 (transmitter empty) always set. Its bit 0 is set exactly when that channel's receive FIFO holds data. All its other bits read 0.
- R5: Read registers 12 and 13 of a channel return the last bytes written to write registers 12 and 13 of the same channel.
- R6: A data-port read pops the oldest byte from that channel's 16-entry receive FIFO and returns it. The same read returns 0x00 when the FIFO is empty.
- R7: A push into a full FIFO is dropped and sets a sticky overrun flag. The flag reads at bit 5 of read register 1 and stays set until reset. All other bits of read register 1 read 0.
- R8: A data-port write produces, in the next cycle, a one-cycle pulse on that channel's bit of tx_stb, with the written byte on tx_data.
- R9: When bit 4 of write register 14 is set, each byte written to that channel's data port is also pushed into the channel's own FIFO. If an external push to the same channel arrives in the same cycle, the loopback byte is kept, the external byte is dropped and the overrun flag is set.
- R10: The pending register is read register 3 of channel A. Bit 4 is TX-pending A, bit 1 is TX-pending B, bit 5 is RX-pending A and bit 2 is RX-pending B. Bits 3 and 0 are the external-pending bits and read 0. Read register 3 of channel B reads 0x00. A data-port write sets that channel's TX-pending bit when bit 3 of write register 9 of channel A and bit 1 of the channel's own write register 1 are both set.
- R11: While bit 3 of write register 9 of channel A is set, bits 4:3 of write register 1 of channel A are not 00, and a channel's FIFO holds data, that channel's RX-pending bit is set. The bit stays set until it is cleared.
- R12: A read of read register 3 on channel A, or a data-port read on either channel, clears every pending bit. In that cycle the clear wins over any set.
- R13: irq is high exactly while some pending bit is set and bit 3 of write register 9 of channel A is set.
- R14: A synchronous active-high reset clears all write registers, both pointers, both FIFOs, the overrun flags and the pending register. After reset, read register 0 reads 0x04 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Channel (bit 3) and port offset (bits 2:0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_valid | input | 2 | Per-channel receive push strobe |
| rx_data | input | 16 | Receive bytes, channel A in bits 7:0 |
| tx_stb | output | 2 | Per-channel transmit pulse |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or a wrong pending state shows up at the next command-port read: a wrong register value appears on rdata one cycle after the strobe, or a stale pointer makes a later read return the wrong register. A FIFO fault shows as a byte out of order or a missing byte on the data-port reads that follow. A missing overrun shows in bit 5 of read register 1. Pending-bit faults show on irq within two cycles of the push or the transmit that should set them, and within one cycle of the read that should clear them.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int CH_BITS = 1;
    localparam int NCH     = 2 ** CH_BITS;
    localparam int DW      = 8;
    localparam int PTR_W   = 4;
    localparam int NREG    = 2 ** PTR_W;

    localparam logic [2:0] OFF_CMD  = 3'd1;
    localparam logic [2:0] OFF_DATA = 3'd5;

    localparam logic [PTR_W-1:0] REG_STAT  = 4'd0;
    localparam logic [PTR_W-1:0] REG_IMODE = 4'd1;
    localparam logic [PTR_W-1:0] REG_PEND  = 4'd3;
    localparam logic [PTR_W-1:0] REG_MIC   = 4'd9;
    localparam logic [PTR_W-1:0] REG_TCLO  = 4'd12;
    localparam logic [PTR_W-1:0] REG_TCHI  = 4'd13;
    localparam logic [PTR_W-1:0] REG_MISC  = 4'd14;

    localparam int IMODE_TXIE  = 1;
    localparam int IMODE_RXLO  = 3;
    localparam int IMODE_RXHI  = 4;
    localparam int MIC_MIE     = 3;
    localparam int MISC_LOOP   = 4;
    localparam int STAT_RXA    = 0;
    localparam int STAT_TXE    = 2;
    localparam int ERR_OVR     = 5;
endpackage

// File: rtl/dsc_rxfifo.sv
module dsc_rxfifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          drop,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          not_empty,
    output logic          ovr,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
        logic                    ovr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = wrap_inc(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if ((push && !do_push) || drop) begin
            st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign not_empty = (st_q.cnt != '0);
    assign dout      = not_empty ? st_q.mem[st_q.rd] : '0;
    assign ovr       = st_q.ovr;
    assign count     = st_q.cnt;
endmodule

// File: rtl/dsc_irq.sv
module dsc_irq
    import dsc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mie,
    input  logic           rx_mode_on,
    input  logic [NCH-1:0] txie,
    input  logic [NCH-1:0] tx_wr,
    input  logic [NCH-1:0] rx_avail,
    input  logic           clr,
    output logic [DW-1:0]  pend_reg,
    output logic           irq
);
    typedef struct packed {
        logic [NCH-1:0] tx_p;
        logic [NCH-1:0] rx_p;
    } irq_st_t;

    irq_st_t        st_d, st_q;
    logic [NCH-1:0] set_tx, set_rx;

    always_comb begin
        set_tx = tx_wr & txie & {NCH{mie}};
        set_rx = rx_avail & {NCH{mie && rx_mode_on}};
        st_d   = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.tx_p = st_q.tx_p | set_tx;
            st_d.rx_p = st_q.rx_p | set_rx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // bit layout: 5 RX A, 4 TX A, 3 ext A, 2 RX B, 1 TX B, 0 ext B
    assign pend_reg = {2'b00, st_q.rx_p[0], st_q.tx_p[0], 1'b0,
                       st_q.rx_p[1], st_q.tx_p[1], 1'b0};
    assign irq = mie && ((st_q.tx_p | st_q.rx_p) != '0);
endmodule

// File: rtl/dsc_regif.sv
module dsc_regif
    import dsc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    rx_valid,
    input  logic [NCH*DW-1:0] rx_data,
    output logic [NCH-1:0]    tx_stb,
    output logic [DW-1:0]     tx_data,
    output logic              irq
);
    typedef struct packed {
        logic [NCH-1:0][NREG-1:0][DW-1:0] wreg;
        logic [NCH-1:0][PTR_W-1:0]        ptr;
        logic [NCH-1:0]                   pend;
        logic [DW-1:0]                    rdata;
        logic [NCH-1:0]                   tx_stb;
        logic [DW-1:0]                    tx_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CH_BITS-1:0]      ch;
    logic [2:0]              off;
    logic                    wr_cmd, wr_dat, rd_cmd, rd_dat, rd_any;
    logic [NCH-1:0]          tx_wr, lb_push, f_push, f_drop, f_pop;
    logic [NCH-1:0][DW-1:0]  f_din, f_dout;
    logic [NCH-1:0]          f_ne, f_ovr;
    logic [NCH-1:0][CW-1:0]  fifo_cnt;
    logic [NCH-1:0]          txie;
    logic [DW-1:0]           pend_reg, rd_val;
    logic                    pend_clr, mie, rx_mode_on;
    logic [PTR_W-1:0]        sel;

    // bus decode
    always_comb begin
        ch     = addr[3 -: CH_BITS];
        off    = addr[2:0];
        wr_cmd = wr_en && (off == OFF_CMD);
        wr_dat = wr_en && (off == OFF_DATA);
        rd_any = rd_en && !wr_en;
        rd_cmd = rd_any && (off == OFF_CMD);
        rd_dat = rd_any && (off == OFF_DATA);
        sel    = st_q.ptr[ch];
    end

    // shared interrupt controls live in channel A
    assign mie        = st_q.wreg[0][REG_MIC][MIC_MIE];
    assign rx_mode_on = (st_q.wreg[0][REG_IMODE][IMODE_RXHI:IMODE_RXLO] != 2'b00);
    assign pend_clr   = rd_dat || (rd_cmd && (ch == '0) && (sel == REG_PEND));

    // per-channel FIFO feed
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            tx_wr[c]   = wr_dat && (ch == CH_BITS'(c));
            lb_push[c] = tx_wr[c] && st_q.wreg[c][REG_MISC][MISC_LOOP];
            f_push[c]  = lb_push[c] || rx_valid[c];
            f_din[c]   = lb_push[c] ? wdata : rx_data[c*DW +: DW];
            f_drop[c]  = lb_push[c] && rx_valid[c];
            f_pop[c]   = rd_dat && (ch == CH_BITS'(c));
            txie[c]    = st_q.wreg[c][REG_IMODE][IMODE_TXIE];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_fifo
        dsc_rxfifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (f_push[c]),
            .din       (f_din[c]),
            .drop      (f_drop[c]),
            .pop       (f_pop[c]),
            .dout      (f_dout[c]),
            .not_empty (f_ne[c]),
            .ovr       (f_ovr[c]),
            .count     (fifo_cnt[c])
        );
    end

    dsc_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .mie        (mie),
        .rx_mode_on (rx_mode_on),
        .txie       (txie),
        .tx_wr      (tx_wr),
        .rx_avail   (f_ne),
        .clr        (pend_clr),
        .pend_reg   (pend_reg),
        .irq        (irq)
    );

    // read register mux for the addressed channel
    always_comb begin
        rd_val = '0;
        case (sel)
            REG_STAT: begin
                rd_val[STAT_TXE] = 1'b1;
                rd_val[STAT_RXA] = f_ne[ch];
            end
            REG_IMODE: rd_val[ERR_OVR] = f_ovr[ch];
            REG_PEND:  rd_val = (ch == '0) ? pend_reg : '0;
            REG_TCLO:  rd_val = st_q.wreg[ch][REG_TCLO];
            REG_TCHI:  rd_val = st_q.wreg[ch][REG_TCHI];
            default:   rd_val = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.tx_stb = '0;
        if (wr_cmd) begin
            if (!st_q.pend[ch]) begin
                st_d.ptr[ch]  = wdata[PTR_W-1:0];
                st_d.pend[ch] = 1'b1;
            end else begin
                st_d.wreg[ch][st_q.ptr[ch]] = wdata;
                st_d.ptr[ch]  = '0;
                st_d.pend[ch] = 1'b0;
            end
        end
        if (wr_dat) begin
            st_d.tx_stb[ch] = 1'b1;
            st_d.tx_data    = wdata;
        end
        if (rd_any) begin
            if (rd_cmd) begin
                st_d.rdata    = rd_val;
                st_d.ptr[ch]  = '0;
                st_d.pend[ch] = 1'b0;
            end else if (rd_dat) begin
                st_d.rdata = f_dout[ch];
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata   = st_q.rdata;
    assign tx_stb  = st_q.tx_stb;
    assign tx_data = st_q.tx_data;
endmodule

// File: rtl/dsc_regif_chk.sv
module dsc_regif_chk
    import dsc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [3:0]             addr,
    input logic [DW-1:0]          wdata,
    input logic [DW-1:0]          rdata,
    input logic [NCH-1:0]         rx_valid,
    input logic [NCH-1:0]         tx_stb,
    input logic [DW-1:0]          tx_data,
    input logic                   irq,
    input logic [NCH-1:0][CW-1:0] fifo_cnt,
    input logic [NCH-1:0]         f_ovr,
    input logic [DW-1:0]          pend_reg,
    input logic [PTR_W-1:0]       ptr_a
);
    logic rd_cmd_a, rd_dat_a;
    assign rd_cmd_a = rd_en && !wr_en && (addr == 4'd1);
    assign rd_dat_a = rd_en && !wr_en && (addr == 4'd5);

    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[2:0] == OFF_DATA) |=>
            ($countones(tx_stb) == 1) && tx_stb[$past(addr[3])] && (tx_data == $past(wdata)));

    // R8
    tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr[2:0] == OFF_DATA) |=> (tx_stb == '0));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid[0] && fifo_cnt[0] == CW'(FIFO_DEPTH) && !rd_dat_a) |=> f_ovr[0]);

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        f_ovr[1] |=> f_ovr[1]);

    // R12
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_a && ptr_a == 4'd3) |=> !irq);

    // R13
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend_reg != '0));

    // R4
    stat_rxa_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_a && ptr_a == 4'd0) |=> rdata[2] && (rdata[0] == ($past(fifo_cnt[0]) != '0)));
endmodule

bind dsc_regif dsc_regif_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rx_valid (rx_valid),
    .tx_stb   (tx_stb),
    .tx_data  (tx_data),
    .irq      (irq),
    .fifo_cnt (fifo_cnt),
    .f_ovr    (f_ovr),
    .pend_reg (pend_reg),
    .ptr_a    (st_q.ptr[0])
);

// File: tb/dsc_regif_tb_top.sv
module dsc_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  rx_valid = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  tx_stb;
    logic [7:0]  tx_data;
    logic        irq;

    int tests = 0, fails = 0;
    bit done = 0;
    logic       rd_seen = 1'b0;
    logic [1:0] tx_seen;
    logic [7:0] tx_seen_d;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [3:0] CMD_A = 4'h1, DAT_A = 4'h5, CMD_B = 4'h9, DAT_B = 4'hD;

    always #4 clk = ~clk;

    dsc_regif dut_i (.*);

    always @(posedge clk) rd_seen <= rd_en;

    // scoreboard monitor: compares registered read data
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata actual 0x%02h expected 0x%02h", t, rdata, e);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        tx_seen = tx_stb; tx_seen_d = tx_data;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_reg(input logic [3:0] cmd, input logic [3:0] idx, input logic [7:0] v);
        bus_wr(cmd, {4'h0, idx});
        bus_wr(cmd, v);
    endtask

    task automatic get_reg(input logic [3:0] cmd, input logic [3:0] idx, input logic [7:0] e,
                           input string t);
        bus_wr(cmd, {4'h0, idx});
        bus_rd(cmd, e, t);
    endtask

    task automatic push_rx(input int c, input logic [7:0] b);
        @(negedge clk);
        rx_valid[c] = 1'b1; rx_data[c*8 +: 8] = b;
        @(negedge clk);
        rx_valid = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R14 reset state
        chk({7'b0, irq}, 8'h00, "R14 irq after reset");
        bus_rd(CMD_A, 8'h04, "R14 RR0 A after reset");
        bus_rd(CMD_B, 8'h04, "R14 RR0 B after reset");
        get_reg(CMD_A, 4'd3, 8'h00, "R14 RR3 after reset");
        get_reg(CMD_A, 4'd12, 8'h00, "R14 WR12 cleared");

        // R5 R2 R3 pointer protocol and mirrors
        set_reg(CMD_A, 4'd12, 8'h5A);
        get_reg(CMD_A, 4'd12, 8'h5A, "R5 RR12 A mirror");
        set_reg(CMD_B, 4'd13, 8'hC3);
        get_reg(CMD_B, 4'd13, 8'hC3, "R5 RR13 B mirror");
        get_reg(CMD_B, 4'd12, 8'h00, "R5 RR12 B separate");
        bus_wr(CMD_A, 8'h2C);
        bus_wr(CMD_A, 8'h81);
        get_reg(CMD_A, 4'd12, 8'h81, "R2 pointer low four bits");
        bus_rd(CMD_A, 8'h04, "R3 pointer back to zero after read");

        // R1 other offsets
        bus_wr(4'h0, 8'h0C);
        bus_rd(CMD_A, 8'h04, "R1 offset 0 write ignored");
        bus_rd(4'h2, 8'h00, "R1 offset 2 reads zero");

        // R4 R6 FIFO order
        push_rx(0, 8'h11);
        push_rx(0, 8'h22);
        bus_rd(CMD_A, 8'h05, "R4 RR0 rx available");
        bus_rd(DAT_A, 8'h11, "R6 first byte");
        bus_rd(DAT_A, 8'h22, "R6 second byte");
        bus_rd(DAT_A, 8'h00, "R6 empty read zero");
        bus_rd(CMD_A, 8'h04, "R4 RR0 after drain");

        // R7 overrun on B
        for (int i = 0; i < 17; i++) push_rx(1, 8'h40 + 8'(i));
        get_reg(CMD_B, 4'd1, 8'h20, "R7 overrun B");
        get_reg(CMD_A, 4'd1, 8'h00, "R7 no overrun A");
        for (int i = 0; i < 16; i++) bus_rd(DAT_B, 8'h40 + 8'(i), "R7 kept bytes");
        bus_rd(DAT_B, 8'h00, "R7 extra byte dropped");
        get_reg(CMD_B, 4'd1, 8'h20, "R7 overrun sticky");

        // R11 R13 receive interrupt
        set_reg(CMD_A, 4'd1, 8'h12);
        set_reg(CMD_A, 4'd9, 8'h08);
        chk({7'b0, irq}, 8'h00, "R13 no pending yet");
        push_rx(0, 8'h77);
        idle(2);
        chk({7'b0, irq}, 8'h01, "R11 rx pending raises irq");
        get_reg(CMD_A, 4'd3, 8'h20, "R10 RX A bit");
        bus_rd(DAT_A, 8'h77, "R6 rx byte");
        idle(2);
        chk({7'b0, irq}, 8'h00, "R12 data read clears");

        // R8 R10 transmit
        bus_wr(DAT_A, 8'h99);
        chk({6'b0, tx_seen}, 8'h01, "R8 strobe A");
        chk(tx_seen_d, 8'h99, "R8 data A");
        chk({7'b0, irq}, 8'h01, "R10 TX A pending");
        get_reg(CMD_A, 4'd3, 8'h10, "R10 TX A bit");
        chk({7'b0, irq}, 8'h00, "R12 RR3 read clears");
        bus_wr(DAT_B, 8'h33);
        chk({6'b0, tx_seen}, 8'h02, "R8 strobe B");
        chk({7'b0, irq}, 8'h00, "R10 B without own enable");
        set_reg(CMD_B, 4'd1, 8'h02);
        bus_wr(DAT_B, 8'h44);
        get_reg(CMD_B, 4'd3, 8'h00, "R10 RR3 B reads zero");
        chk({7'b0, irq}, 8'h01, "R10 RR3 B read leaves pending");
        get_reg(CMD_A, 4'd3, 8'h02, "R10 TX B bit");

        // R9 loopback with interrupts off
        set_reg(CMD_A, 4'd9, 8'h00);
        set_reg(CMD_A, 4'd14, 8'h10);
        bus_wr(DAT_A, 8'hAB);
        chk({7'b0, irq}, 8'h00, "R13 master off");
        get_reg(CMD_A, 4'd3, 8'h00, "R10 no pend while master off");
        bus_rd(CMD_A, 8'h05, "R9 loopback fills FIFO");
        bus_rd(DAT_A, 8'hAB, "R9 loopback byte");

        // R9 collision
        @(negedge clk);
        wr_en = 1'b1; addr = DAT_A; wdata = 8'hEE;
        rx_valid[0] = 1'b1; rx_data[7:0] = 8'h55;
        @(negedge clk);
        wr_en = 1'b0; rx_valid = '0;
        get_reg(CMD_A, 4'd1, 8'h20, "R9 collision overrun");
        bus_rd(DAT_A, 8'hEE, "R9 loopback byte kept");
        bus_rd(DAT_A, 8'h00, "R9 external byte dropped");

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule